// File: doc/BRIEF.md
# Sixteen-Opcode Register-File Processor Core

This block is a single-cycle processor core with a 16-bit data path. On every clock it takes the instruction presented on its instruction-memory read port and executes it before the next edge. The instruction port is addressed by the program counter, and the instruction data is read combinationally. Each instruction carries a 4-bit opcode and three 4-bit register fields. The operation set covers bitwise logic, addition, multiplication, unsigned division, logical shifts, memory load and store, register copy and four register-indirect jumps.

The register file has eight entries. Entry 3 serves as the compare register that the conditional jumps test. Entry 7 is the program counter, which is readable and writable like any other register. The data-memory port has an address, write data, a write enable and read data. Store writes on the clock edge that ends the instruction. Load takes the read data combinationally within the same cycle.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous reset clears all eight registers, including the program counter, so `imem_addr` reads 0 after reset.
- R2: Fields are decoded as opcode bits 15:12, first source 11:8, second source 7:4 and destination 3:0. Each register field selects a register by its low three bits only, and bit 3 of a field is ignored.
- R3: Opcodes 0000, 0001 and 0010 write src1 AND, OR and XOR src2 to the destination. Opcode 0011 writes the bitwise inverse of src1.
- R4: Opcode 0100 writes (src1 + src2) mod 2^16. Opcode 0101 writes the low 16 bits of src1 * src2.
- R5: Opcode 0110 writes the unsigned quotient src1 / src2. A zero divisor writes 16'hFFFF.
- R6: Opcodes 0111 and 1000 shift src1 left and right logically by the unsigned value of src2. Any amount of 16 or more gives 0.
- R7: Opcode 1011 copies src1 to the destination unchanged.
- R8: Opcode 1001 drives `dmem_addr` with src1 and writes `dmem_rdata` into the destination in the same cycle.
- R9: Opcode 1010 drives `dmem_addr` with src1 and `dmem_wdata` with src2, and it holds `dmem_we` high. `dmem_we` is low for every other opcode. Stores and jumps write no register.
- R10: Opcode 1100 always loads the PC from the register named in bits 11:8. Opcodes 1101, 1110 and 1111 do the same only when the compare register (code 3), read as signed, is equal to, below or above zero.
- R11: Otherwise the PC advances by one. An instruction whose destination is register 7 sets the next PC to its result.
- R12: Reading register 7 as a source returns the address of the executing instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word for the current address |
| dmem_addr | output | 16 | Data-memory address (first source register) |
| dmem_wdata | output | 16 | Data-memory write data (second source register) |
| dmem_we | output | 1 | Data-memory write enable, high during a store |
| dmem_rdata | input | 16 | Data-memory read data, used by loads |

## Verification
Two updates can land in the same cycle: the implicit program-counter increment, and an ordinary register write whose destination field names register 7. The result must be one new PC. A register-7 write must replace the increment, and a taken jump must override both. Directed copies and loads into register 7 provoke this case, and so do random instructions whose destination fields often select 7. Each case is judged by comparing the next `imem_addr` and a read-back of register 7 against a bench model.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0,
    OP_OR  = 4'h1,
    OP_XOR = 4'h2,
    OP_NOT = 4'h3,
    OP_ADD = 4'h4,
    OP_MUL = 4'h5,
    OP_DIV = 4'h6,
    OP_SHL = 4'h7,
    OP_SHR = 4'h8,
    OP_LD  = 4'h9,
    OP_ST  = 4'hA,
    OP_MOV = 4'hB,
    OP_JMP = 4'hC,
    OP_JEQ = 4'hD,
    OP_JLT = 4'hE,
    OP_JGT = 4'hF
  } op_e;

  localparam int unsigned INSN_W  = 16;
  localparam int unsigned FIELD_W = 4;

endpackage

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile #(
  parameter int unsigned W       = 16,
  parameter int unsigned NREG    = 8,
  parameter int unsigned PC_IDX  = 7,
  parameter int unsigned CMP_IDX = 3,
  localparam int unsigned IDX_W  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra1,
  input  logic [IDX_W-1:0] ra2,
  output logic [W-1:0]     rd1,
  output logic [W-1:0]     rd2,
  output logic [W-1:0]     cmp_q,
  output logic [W-1:0]     pc_q,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [W-1:0]     pc_d
);

  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [W-1:0] r;
    if (i == PC_IDX) begin : g_pc
      // the PC entry always takes the resolved next address
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= pc_d;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)                             r <= '0;
        else if (we && wa == IDX_W'(i))      r <= wd;
      end
    end
    assign q[i] = r;
  end

  assign rd1   = q[ra1];
  assign rd2   = q[ra2];
  assign cmp_q = q[CMP_IDX];
  assign pc_q  = q[PC_IDX];

endmodule

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] SH_LIM = W'(W);

  function automatic logic [W-1:0] f_shl(input logic [W-1:0] v, input logic [W-1:0] n);
    if (n >= SH_LIM) return '0;
    return v << n[SH_W-1:0];
  endfunction

  function automatic logic [W-1:0] f_shr(input logic [W-1:0] v, input logic [W-1:0] n);
    if (n >= SH_LIM) return '0;
    return v >> n[SH_W-1:0];
  endfunction

  function automatic logic [W-1:0] f_div(input logic [W-1:0] n, input logic [W-1:0] d);
    if (d == '0) return '1;
    return n / d;
  endfunction

  function automatic logic [W-1:0] f_mul(input logic [W-1:0] x, input logic [W-1:0] z);
    return x * z;
  endfunction

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_ADD:  y = a + b;
      OP_MUL:  y = f_mul(a, b);
      OP_DIV:  y = f_div(a, b);
      OP_SHL:  y = f_shl(a, b);
      OP_SHR:  y = f_shr(a, b);
      default: y = a;   // MOV and non-ALU opcodes pass src1
    endcase
  end

endmodule

// File: rtl/cpu16_flow.sv
`timescale 1ns/1ps
module cpu16_flow
  import cpu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] tgt,
  input  logic [W-1:0] cmp,
  input  logic         wr_pc,
  input  logic [W-1:0] wr_val,
  output logic         jump_taken,
  output logic [W-1:0] pc_d
);

  logic cmp_zero, cmp_neg;
  assign cmp_zero = (cmp == '0);
  assign cmp_neg  = cmp[W-1];

  always_comb begin
    case (op)
      OP_JMP:  jump_taken = 1'b1;
      OP_JEQ:  jump_taken = cmp_zero;
      OP_JLT:  jump_taken = cmp_neg;
      OP_JGT:  jump_taken = !cmp_neg && !cmp_zero;
      default: jump_taken = 1'b0;
    endcase
  end

  // priority: taken jump, then explicit PC write, then increment
  always_comb begin
    if (jump_taken)  pc_d = tgt;
    else if (wr_pc)  pc_d = wr_val;
    else             pc_d = pc_q + W'(1);
  end

endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned NREG    = 8,
  parameter int unsigned CMP_IDX = 3
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] imem_addr,
  input  logic [15:0]  imem_data,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata
);

  localparam int unsigned IDX_W  = $clog2(NREG);
  localparam int unsigned PC_IDX = NREG - 1;
  localparam logic [FIELD_W-1:0] FLD_MOD = FIELD_W'(NREG);

  op_e              op;
  logic [IDX_W-1:0] s1_idx, s2_idx, d_idx;
  logic [W-1:0]     rd1, rd2, cmp_q, pc_q, pc_d, alu_y;
  logic [W-1:0]     wr_val;
  logic             wr_en, wr_pc, jump_taken;

  // field decode: register codes use the field modulo the register count
  assign op     = op_e'(imem_data[15:12]);
  assign s1_idx = IDX_W'(imem_data[11:8] % FLD_MOD);
  assign s2_idx = IDX_W'(imem_data[7:4]  % FLD_MOD);
  assign d_idx  = IDX_W'(imem_data[3:0]  % FLD_MOD);

  assign wr_en  = !(op inside {OP_ST, OP_JMP, OP_JEQ, OP_JLT, OP_JGT});
  assign wr_pc  = wr_en && (d_idx == IDX_W'(PC_IDX));
  assign wr_val = (op == OP_LD) ? dmem_rdata : alu_y;

  cpu16_regfile #(
    .W(W), .NREG(NREG), .PC_IDX(PC_IDX), .CMP_IDX(CMP_IDX)
  ) u_rf (
    .clk(clk), .rst(rst),
    .ra1(s1_idx), .ra2(s2_idx),
    .rd1(rd1), .rd2(rd2), .cmp_q(cmp_q), .pc_q(pc_q),
    .we(wr_en), .wa(d_idx), .wd(wr_val), .pc_d(pc_d)
  );

  cpu16_alu #(.W(W)) u_alu (
    .op(op), .a(rd1), .b(rd2), .y(alu_y)
  );

  cpu16_flow #(.W(W)) u_flow (
    .op(op), .pc_q(pc_q), .tgt(rd1), .cmp(cmp_q),
    .wr_pc(wr_pc), .wr_val(wr_val),
    .jump_taken(jump_taken), .pc_d(pc_d)
  );

  assign imem_addr  = pc_q;
  assign dmem_addr  = rd1;
  assign dmem_wdata = rd2;
  assign dmem_we    = (op == OP_ST);

endmodule

// File: rtl/cpu16_chk.sv
`timescale 1ns/1ps
module cpu16_chk
  import cpu16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] imem_addr,
  input op_e          op,
  input logic         jump_taken,
  input logic [W-1:0] jump_tgt,
  input logic         wr_en,
  input logic         wr_pc,
  input logic [W-1:0] wr_val,
  input logic         dmem_we
);

  // R1: the cycle after reset fetches from address zero
  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> imem_addr == '0);

  // R10: a taken jump lands on the target register value
  a_r10_jump_lands: assert property (@(posedge clk) disable iff (rst)
    jump_taken |=> imem_addr == $past(jump_tgt));

  // R10: only branch opcodes can take a jump
  a_r10_jump_op: assert property (@(posedge clk) disable iff (rst)
    jump_taken |-> op inside {OP_JMP, OP_JEQ, OP_JLT, OP_JGT});

  // R11: with no jump and no PC write the fetch address steps by one
  a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!jump_taken && !wr_pc) |=> imem_addr == $past(imem_addr) + W'(1));

  // R11: a write to register 7 sets the next fetch address
  a_r11_pc_write: assert property (@(posedge clk) disable iff (rst)
    wr_pc |=> imem_addr == $past(wr_val));

  // R9: a store never writes the register file
  a_r9_store_no_wr: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !wr_en);

endmodule

bind cpu16_core cpu16_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .op(op),
  .jump_taken(jump_taken), .jump_tgt(rd1), .wr_en(wr_en),
  .wr_pc(wr_pc), .wr_val(wr_val), .dmem_we(dmem_we)
);

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int errs = 0;
  int checks = 0;
  logic [15:0] m [8];   // bench model, m[7] is the PC

  always #2 clk = ~clk;

  cpu16_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input int op, input int a, input int b, input int d);
    return {op[3:0], a[3:0], b[3:0], d[3:0]};
  endfunction

  // expected behaviour, restated from the requirements
  function automatic void model(input logic [15:0] w, input logic [15:0] rd);
    logic [15:0] a, b, c, v, nx;
    logic [31:0] p;
    bit wr, jt;
    a = m[w[10:8]]; b = m[w[6:4]]; c = m[3];
    nx = m[7] + 16'd1; wr = 1; jt = 0; v = '0;
    case (w[15:12])
      4'h0: v = a & b;
      4'h1: v = a | b;
      4'h2: v = a ^ b;
      4'h3: v = ~a;
      4'h4: v = a + b;
      4'h5: begin p = a * b; v = p[15:0]; end
      4'h6: v = (b == 0) ? 16'hFFFF : a / b;
      4'h7: v = (b > 15) ? 16'h0 : a << b[3:0];
      4'h8: v = (b > 15) ? 16'h0 : a >> b[3:0];
      4'h9: v = rd;
      4'hA: wr = 0;
      4'hB: v = a;
      4'hC: begin wr = 0; jt = 1; end
      4'hD: begin wr = 0; jt = (c == 0); end
      4'hE: begin wr = 0; jt = c[15]; end
      default: begin wr = 0; jt = !c[15] && (c != 0); end
    endcase
    if (jt) nx = a;
    else if (wr && w[2:0] == 3'd7) nx = v;
    if (wr && w[2:0] != 3'd7) m[w[2:0]] = v;
    m[7] = nx;
  endfunction

  task automatic compare_state(input string tag);
    chk(imem_addr === m[7], {tag, " pc"}, imem_addr, m[7]);
    for (int r = 0; r < 8; r++) begin
      imem_data = ins(4'hA, 0, r, 0);   // store exposes register r on dmem_wdata
      #0.1;
      chk(dmem_wdata === m[r], $sformatf("%s reg%0d", tag, r), dmem_wdata, m[r]);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic [15:0] rd, input string tag);
    imem_data = w; dmem_rdata = rd;
    #0.2;
    if (w[15:12] == 4'hA) begin
      chk(dmem_we === 1'b1, "R9 we", {15'd0, dmem_we}, 16'd1);
      chk(dmem_addr === m[w[10:8]] && dmem_wdata === m[w[6:4]], "R9 addr/data",
          dmem_wdata, m[w[6:4]]);
    end else begin
      chk(dmem_we === 1'b0, "R9 we low", {15'd0, dmem_we}, 16'd0);
      if (w[15:12] == 4'h9)
        chk(dmem_addr === m[w[10:8]], "R8 addr", dmem_addr, m[w[10:8]]);
    end
    model(w, rd);
    @(posedge clk); @(negedge clk);
    compare_state(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    imem_data = ins(4'hB, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 8; r++) m[r] = '0;
    compare_state("R1");
  endtask

  task automatic ld(input int d, input logic [15:0] v);
    step(ins(4'h9, 0, 0, d), v, "R8");
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    imem_data = '0; dmem_rdata = '0;
    @(negedge clk);
    do_reset();

    // R4 wrap and truncation
    ld(1, 16'hFFFF); ld(2, 16'h0002);
    step(ins(4'h4, 1, 2, 0), 0, "R4 add wrap");
    ld(1, 16'h1234); ld(2, 16'h0100);
    step(ins(4'h5, 1, 2, 0), 0, "R4 mul low");
    // R5 divide and zero divisor
    ld(1, 16'd100); ld(2, 16'd7);
    step(ins(4'h6, 1, 2, 0), 0, "R5 div");
    ld(2, 16'd0);
    step(ins(4'h6, 1, 2, 0), 0, "R5 div zero");
    // R6 shift boundaries
    ld(1, 16'h8001); ld(2, 16'd15);
    step(ins(4'h7, 1, 2, 0), 0, "R6 shl 15");
    step(ins(4'h8, 1, 2, 4), 0, "R6 shr 15");
    ld(2, 16'd16);
    step(ins(4'h7, 1, 2, 0), 0, "R6 shl 16");
    ld(2, 16'hFFFF);
    step(ins(4'h8, 1, 2, 0), 0, "R6 shr big");
    // R3 logic
    ld(1, 16'hF0F0); ld(2, 16'h3C3C);
    step(ins(4'h0, 1, 2, 0), 0, "R3 and");
    step(ins(4'h1, 1, 2, 4), 0, "R3 or");
    step(ins(4'h2, 1, 2, 5), 0, "R3 xor");
    step(ins(4'h3, 1, 0, 6), 0, "R3 not");
    // R2 upper field bit ignored
    step(ins(4'h4, 9, 4'hA, 4'h8), 0, "R2 hi bit");
    // R7 copy, R12 PC as source
    step(ins(4'hB, 2, 0, 5), 0, "R7 mov");
    step(ins(4'hB, 7, 0, 0), 0, "R12 pc read");
    // R9 store
    step(ins(4'hA, 1, 2, 0), 0, "R9 store");
    // R10 conditional jumps on compare register
    ld(4, 16'h0040);
    ld(3, 16'h0000);
    step(ins(4'hD, 4, 0, 0), 0, "R10 jeq taken");
    step(ins(4'hE, 4, 0, 0), 0, "R10 jlt not");
    ld(3, 16'hFFFF);
    step(ins(4'hE, 4, 0, 0), 0, "R10 jlt taken");
    step(ins(4'hF, 4, 0, 0), 0, "R10 jgt not");
    step(ins(4'hD, 4, 0, 0), 0, "R10 jeq not");
    ld(3, 16'h0001);
    step(ins(4'hF, 4, 0, 0), 0, "R10 jgt taken");
    ld(5, 16'h1230);
    step(ins(4'hC, 5, 0, 0), 0, "R10 jmp");
    // R11 PC written as destination
    ld(6, 16'h0777);
    step(ins(4'hB, 6, 0, 7), 0, "R11 pc write");
    step(ins(4'h9, 0, 0, 7), 16'h2000, "R11 load pc");
    // R1 reset mid-run
    do_reset();

    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 5 == 0) w[2:0] = 3'd7;
      step(w, 16'($urandom), "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule